// File: doc/BRIEF.md
# Prioritised Level-Sensitive Interrupt Controller

This block collects 71 level-sensitive request lines and presents them to two processor targets. Each source has its own configuration word with a 4-bit priority, an enable bit, a one-bit target select and an active-low bit. Each of these fields has its own write-enable bit inside the same written word. Software can therefore change one field of a source without first reading the word back. Source 0 is reserved. Its index is the code for "nothing pending", so it can never be configured and can never win.

Each target has a 4-bit threshold register and a vector register. In every cycle the controller finds, for each target, the qualifying source with the highest priority, with ties going to the lower index. It registers that source's index together with a per-target interrupt line. A processor reads the vector register to learn which source to service. It raises the threshold to block lower-priority work.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every source word, both threshold registers and both vector base fields read 0, and both `irq_o` lines are low.
- R2: A source word holds its priority in bits 3:0, and reads return it there. A write changes the priority only when bit 28 of the written data is 1; otherwise the stored priority is kept.
- R3: The enable bit (bit 16) changes only when bit 26 of the written data is 1. The target bit (bit 17) changes only when bit 27 is 1. The active-low bit (bit 18) changes only when bit 25 is 1. Each field is guarded independently of the others.
- R4: Writing 0x1E000000 to a source word clears all four fields. The source is then disabled, routed to target 0, active high and at priority 0.
- R5: Source 0 ignores writes, always reads 0 and never appears in a vector, even when its request line is high.
- R6: When a source's active-low bit is 1, its request line is inverted before any qualification.
- R7: A source qualifies for target t when four conditions hold: its corrected level is 1, it is enabled, its target bit equals t, and its priority is strictly greater than the threshold of t. `irq_o[t]` is high exactly when some source qualified in the previous cycle.
- R8: The vector of target t names the qualifying source with the highest priority, with ties going to the lowest index. It is 0 when no source qualifies. It is recomputed every cycle and registered, so it tracks the levels one cycle late.
- R9: Bus map: addresses 0..70 are source words, 0x80 and 0x81 are the thresholds of targets 0 and 1 (bits 3:0), and 0x82 and 0x83 are their vector registers. A vector register reads as base<<11 | index<<3. Only the base field (bits 31:11) is writable; the other bits are read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 71 | Request levels, one per source |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 2 | Interrupt line per target |

## Verification
The assertions assume that the request lines and the bus are synchronous to `clk`. They also assume that a source write refers to an address below 71 whenever its effect on a stored field is being checked. The bench drives every input on the falling edge and addresses only mapped registers. It mixes seeded random writes, including the clear-all word and guarded partial writes, with random request patterns. Outputs are sampled one full cycle after the last change.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NSRC     = 71;
  localparam int NTGT     = 2;
  localparam int PRIO_W   = 4;
  localparam int DW       = 32;
  localparam int AW       = 8;
  localparam int IDX_W    = $clog2(NSRC);
  localparam int BASE_W   = DW - IDX_W - 4;

  // field positions in a source word
  localparam int B_EN     = 16;
  localparam int B_TGT    = 17;
  localparam int B_POL    = 18;
  localparam int B_POL_WE = 25;
  localparam int B_EN_WE  = 26;
  localparam int B_TGT_WE = 27;
  localparam int B_PRI_WE = 28;

  typedef struct packed {
    logic              pol;
    logic              tgt;
    logic              en;
    logic [PRIO_W-1:0] prio;
  } src_cfg_t;

  // apply a guarded write to one source word
  function automatic src_cfg_t merge_write(src_cfg_t cur, logic [DW-1:0] d);
    src_cfg_t n;
    n = cur;
    if (d[B_PRI_WE]) n.prio = d[PRIO_W-1:0];
    if (d[B_EN_WE])  n.en   = d[B_EN];
    if (d[B_TGT_WE]) n.tgt  = d[B_TGT];
    if (d[B_POL_WE]) n.pol  = d[B_POL];
    return n;
  endfunction

  function automatic logic [DW-1:0] show_src(src_cfg_t c);
    logic [DW-1:0] w;
    w = '0;
    w[PRIO_W-1:0] = c.prio;
    w[B_EN]       = c.en;
    w[B_TGT]      = c.tgt;
    w[B_POL]      = c.pol;
    return w;
  endfunction

  function automatic logic eligible(src_cfg_t c, logic lvl, logic tsel,
                                    logic [PRIO_W-1:0] thr);
    return lvl && c.en && (c.tgt == tsel) && (c.prio > thr);
  endfunction

  function automatic logic [DW-1:0] show_vec(logic [BASE_W-1:0] b,
                                             logic [IDX_W-1:0] i);
    return {b, 1'b0, i, 3'b000};
  endfunction
endpackage

// File: rtl/pic_src_bank.sv
module pic_src_bank
  import pic_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [DW-1:0]          wr_data,
  output src_cfg_t [NSRC-1:0]    cfg
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i == 0) begin : g_rsvd
      // reserved "nothing pending" code: no storage
      assign cfg[i] = '0;
    end else begin : g_live
      src_cfg_t q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= '0;
        else if (wr_en && wr_idx == IDX_W'(i))
          q <= merge_write(q, wr_data);
      end
      assign cfg[i] = q;
    end
  end
endmodule

// File: rtl/pic_pick.sv
module pic_pick
  import pic_pkg::*;
#(
  parameter int TGT = 0
)(
  input  src_cfg_t [NSRC-1:0] cfg,
  input  logic [NSRC-1:0]     lvl,
  input  logic [PRIO_W-1:0]   thr,
  output logic                hit,
  output logic [IDX_W-1:0]    idx
);
  localparam logic TSEL = 1'(TGT);

  logic [PRIO_W-1:0] best;

  // ascending scan, strict compare keeps the lowest index on ties
  always_comb begin
    best = '0;
    hit  = 1'b0;
    idx  = '0;
    for (int i = 1; i < NSRC; i++) begin
      if (eligible(cfg[i], lvl[i], TSEL, thr) && (!hit || cfg[i].prio > best)) begin
        hit  = 1'b1;
        best = cfg[i].prio;
        idx  = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req_i,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NTGT-1:0]   irq_o
);
  localparam logic [AW-1:0] A_THR0 = AW'(8'h80);
  localparam logic [AW-1:0] A_VEC0 = AW'(8'h80 + NTGT);

  src_cfg_t [NSRC-1:0]               cfg;
  logic [NSRC-1:0]                   lvl;
  logic [NTGT-1:0][PRIO_W-1:0]       mask_q;
  logic [NTGT-1:0][BASE_W-1:0]       base_q;
  logic [NTGT-1:0][IDX_W-1:0]        win_q;
  logic [NTGT-1:0]                   irq_q;

  logic                              sel_src;
  logic [IDX_W-1:0]                  src_idx;

  assign sel_src = (bus_addr < AW'(NSRC));
  assign src_idx = bus_addr[IDX_W-1:0];

  pic_src_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr && sel_src),
    .wr_idx  (src_idx),
    .wr_data (bus_wdata),
    .cfg     (cfg)
  );

  // polarity correction ahead of all other logic
  for (genvar i = 0; i < NSRC; i++) begin : g_pol
    assign lvl[i] = req_i[i] ^ cfg[i].pol;
  end

  for (genvar t = 0; t < NTGT; t++) begin : g_tgt
    logic [PRIO_W-1:0] thr_r;
    logic [BASE_W-1:0] base_r;
    logic [IDX_W-1:0]  win_r;
    logic              irq_r;
    logic              hit;
    logic [IDX_W-1:0]  idx;

    pic_pick #(.TGT(t)) u_pick (
      .cfg (cfg),
      .lvl (lvl),
      .thr (thr_r),
      .hit (hit),
      .idx (idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        thr_r  <= '0;
        base_r <= '0;
        win_r  <= '0;
        irq_r  <= 1'b0;
      end else begin
        if (bus_wr && bus_addr == A_THR0 + AW'(t))
          thr_r <= bus_wdata[PRIO_W-1:0];
        if (bus_wr && bus_addr == A_VEC0 + AW'(t))
          base_r <= bus_wdata[DW-1 -: BASE_W];
        win_r <= idx;
        irq_r <= hit;
      end
    end

    assign mask_q[t] = thr_r;
    assign base_q[t] = base_r;
    assign win_q[t]  = win_r;
    assign irq_q[t]  = irq_r;
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_src)
      bus_rdata = show_src(cfg[src_idx]);
    for (int t = 0; t < NTGT; t++) begin
      if (bus_addr == A_THR0 + AW'(t))
        bus_rdata = DW'(mask_q[t]);
      if (bus_addr == A_VEC0 + AW'(t))
        bus_rdata = show_vec(base_q[t], win_q[t]);
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/pic_checks.sv
module pic_checks
  import pic_pkg::*;
(
  input logic                        clk,
  input logic                        rst_n,
  input logic [NTGT-1:0]             irq_o,
  input logic [NTGT-1:0][IDX_W-1:0]  win_idx,
  input logic [NTGT-1:0][PRIO_W-1:0] mask,
  input src_cfg_t [NSRC-1:0]         cfg,
  input logic                        bus_wr,
  input logic [AW-1:0]               bus_addr,
  input logic [DW-1:0]               bus_wdata
);
  logic src_wr;
  assign src_wr = bus_wr && (bus_addr < AW'(NSRC));

  // R1: reset keeps both lines low
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |=> (irq_o == '0));

  // R2: priority kept when its write enable is clear
  a_r2_prio_held: assert property (@(posedge clk) disable iff (!rst_n)
    (src_wr && !bus_wdata[B_PRI_WE]) |=>
      (cfg[$past(bus_addr)].prio == $past(cfg[bus_addr].prio)));

  // R3: enable kept when its write enable is clear
  a_r3_enable_held: assert property (@(posedge clk) disable iff (!rst_n)
    (src_wr && !bus_wdata[B_EN_WE]) |=>
      (cfg[$past(bus_addr)].en == $past(cfg[bus_addr].en)));

  // R4: the clear-all word empties a live source
  a_r4_clear_word: assert property (@(posedge clk) disable iff (!rst_n)
    (src_wr && bus_addr != '0 && bus_wdata == 32'h1E00_0000) |=>
      (cfg[$past(bus_addr)] == '0));

  for (genvar t = 0; t < NTGT; t++) begin : g_t
    // R7 / R8: line and vector agree
    a_r7_line_matches_vector: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[t] == (win_idx[t] != '0));

    // R7: a full threshold blocks every source
    a_r7_full_mask_silences: assert property (@(posedge clk) disable iff (!rst_n)
      (mask[t] == {PRIO_W{1'b1}}) |=> !irq_o[t]);
  end
endmodule

bind prio_irq_ctrl pic_checks u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_o     (irq_o),
  .win_idx   (win_q),
  .mask      (mask_q),
  .cfg       (cfg),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata)
);

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;
  localparam int N = 71;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq_o;

  always #5 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o)
  );

  // reference state
  bit [3:0]  m_prio [N];
  bit        m_en   [N];
  bit        m_tgt  [N];
  bit        m_pol  [N];
  bit [3:0]  m_mask [2];
  bit [20:0] m_base [2];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic int ref_pick(int t);
    int bi = 0;
    int bp = 0;
    for (int i = 1; i < N; i++) begin
      bit lv = req[i] ^ m_pol[i];
      if (lv && m_en[i] && (m_tgt[i] == t[0]) && (m_prio[i] > m_mask[t]) && (m_prio[i] > bp)) begin
        bp = m_prio[i];
        bi = i;
      end
    end
    return bi;
  endfunction

  function automatic logic [31:0] ref_src(int a);
    if (a == 0) return 32'h0;
    return {13'h0, m_pol[a], m_tgt[a], m_en[a], 12'h0, m_prio[a]};
  endfunction

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a > 0 && a < N) begin
      if (d[28]) m_prio[a] = d[3:0];
      if (d[26]) m_en[a]   = d[16];
      if (d[27]) m_tgt[a]  = d[17];
      if (d[25]) m_pol[a]  = d[18];
    end else if (a == 8'h80 || a == 8'h81) m_mask[a[0]] = d[3:0];
    else if (a == 8'h82 || a == 8'h83) m_base[a[0]] = d[31:11];
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic check_targets(string tag);
    logic [31:0] v;
    for (int t = 0; t < 2; t++) begin
      int w = ref_pick(t);
      bus_read(8'h82 + 8'(t), v);
      check({tag, " R8 vector"}, v, {m_base[t], 1'b0, 7'(w), 3'b000});
      check({tag, " R7 line"}, 32'(irq_o[t]), 32'(w != 0));
    end
  endtask

  task automatic check_src(string tag, int a);
    logic [31:0] v;
    bus_read(8'(a), v);
    check(tag, v, ref_src(a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all R): got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", 32'(irq_o), 32'h0);
    check_src("R1 src word", 33);
    bus_read(8'h80, v); check("R1 thr0", v, 32'h0);
    bus_read(8'h81, v); check("R1 thr1", v, 32'h0);
    check_targets("R1");

    // R2 guarded priority
    bus_write(5, 32'h1000_0007); check_src("R2 prio set", 5);
    bus_write(5, 32'h0000_0003); check_src("R2 prio kept", 5);
    // R3 each field on its own guard
    bus_write(5, 32'h0401_0000); check_src("R3 enable", 5);
    bus_write(5, 32'h0802_0000); check_src("R3 target", 5);
    bus_write(5, 32'h0204_0000); check_src("R3 polarity", 5);
    bus_write(5, 32'h0007_000F); check_src("R3 unguarded ignored", 5);
    // R4 clear word
    bus_write(5, 32'h1E00_0000); check_src("R4 clear", 5);
    // R5 reserved source
    bus_write(0, 32'h1E07_000F); check_src("R5 src0 read", 0);
    req = '0; req[0] = 1'b1; settle(); check_targets("R5 src0 req");

    // R6 / R7 qualification
    bus_write(9, 32'h1401_0004);
    req = '0; settle(); check_targets("R7 low level");
    req[9] = 1'b1; settle(); check_targets("R7 high level");
    bus_write(9, 32'h0204_0000); req[9] = 1'b0; settle(); check_targets("R6 active low");
    bus_write(8'h80, 32'h4); settle(); check_targets("R7 prio equals mask");
    bus_write(8'h80, 32'h3); settle(); check_targets("R7 mask below");
    bus_write(8'h80, 32'h0);

    // R8 ties and extremes
    bus_write(20, 32'h1401_0006); bus_write(12, 32'h1401_0006);
    req[20] = 1'b1; req[12] = 1'b1; settle(); check_targets("R8 tie");
    bus_write(40, 32'h1401_0009); req[40] = 1'b1; settle(); check_targets("R8 higher");
    bus_write(70, 32'h1C03_000F); req[70] = 1'b1; settle(); check_targets("R8 last src other target");
    // R9 base field
    bus_write(8'h82, 32'hFFFF_FFFF); bus_write(8'h83, 32'hA5A5_A5A5);
    settle(); check_targets("R9 base");

    // random phase
    for (int it = 0; it < 400; it++) begin
      int nw = $urandom_range(0, 3);
      for (int k = 0; k < nw; k++) begin
        logic [7:0]  a;
        logic [31:0] d;
        int sel = $urandom_range(0, 9);
        if (sel < 8) a = 8'($urandom_range(0, N - 1));
        else a = 8'h80 + 8'($urandom_range(0, 3));
        d = $urandom;
        if ($urandom_range(0, 15) == 0) d = 32'h1E00_0000;
        if (a == 8'h80 || a == 8'h81) d[3:0] = 4'($urandom_range(0, 6));
        bus_write(a, d);
      end
      @(negedge clk);
      req = {$urandom, $urandom, $urandom};
      settle();
      check_targets("R7 R8 random");
      check_src("R2 R3 random src", $urandom_range(0, N - 1));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule